// File: doc/BRIEF.md
# Serial Triplet Bootstrap Loader

This block is a hardware cold-boot engine that sits between a byte source and a simple write bus while a processor is held out of normal execution. After reset, if both startup straps are high, it accepts bytes from one of two ready/valid byte sources (a serial receiver or a parallel slave port, picked by a third strap). It groups the bytes into three-byte records and turns each complete record into a single write on the bus. Each record names its own target space, memory or I/O, through the top bit of its first byte.

A host uses the engine to place registers and a small program into the system one triplet at a time. It finishes by sending one particular I/O write. When that write completes, the engine drops its active flag, stops taking bytes, and gives the processor a one-cycle start pulse with fetch address zero.

Top module: `boot_triplet_loader`

## Requirements
- R1: In each reset cycle (rst high) the straps are sampled. After reset, boot_active is 1 exactly when strap_a and strap_b were both 1; otherwise it is 0 and the engine stays idle.
- R2: Accepted bytes form records in a fixed order: first the address high byte, then the address low byte, then the data byte. When bit 7 of the high byte is 0, the write goes to memory (wr_io = 0), wr_addr = {high, low} and wr_data = the data byte.
- R3: When bit 7 of the high byte is 1, the write goes to I/O space (wr_io = 1), and wr_addr is {high, low} with bit 15 forced to 0.
- R4: If the next byte of a record is absent for any number of cycles, the engine keeps its place in the record and resumes with the following accepted byte.
- R5: Each completed record produces exactly one wr_en pulse, one clock wide, in the cycle after its third byte is accepted. An incomplete record produces no pulse.
- R6: strap_src sampled at reset picks the source: 0 for the serial port, 1 for the parallel port. Only the picked source sees ready. Bytes offered on the other source are not taken and do not move the record position.
- R7: The record 0x80, 0x24, 0x80 (an I/O write of 0x80 to address 0x0024) is issued as a normal write. One cycle later boot_active falls to 0 and fetch_go pulses high for one cycle, with fetch_addr = 0x0000.
- R8: While boot_active is 0, both ready outputs stay 0, no byte is taken and wr_en stays 0.
- R9: During the strobe cycle of an ordinary write, the picked source stays ready, so the next record's first byte can be taken in that cycle. During the strobe cycle of the terminating write, ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| strap_a | input | 1 | Startup strap, first of the pair that enables boot |
| strap_b | input | 1 | Startup strap, second of the pair that enables boot |
| strap_src | input | 1 | Source strap: 0 serial, 1 parallel |
| ser_valid | input | 1 | Serial byte available |
| ser_data | input | 8 | Serial byte |
| ser_ready | output | 1 | Serial byte taken at this edge when valid |
| par_valid | input | 1 | Parallel byte available |
| par_data | input | 8 | Parallel byte |
| par_ready | output | 1 | Parallel byte taken at this edge when valid |
| wr_en | output | 1 | One-cycle write strobe |
| wr_io | output | 1 | 1 = I/O space, 0 = memory |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| boot_active | output | 1 | Engine is loading |
| fetch_go | output | 1 | One-cycle pulse: processor may begin fetching |
| fetch_addr | output | 16 | Address where fetching begins |

## Verification
Two events can land in the same cycle: the write strobe of a finished record and the acceptance of the first byte of the next record. The bench provokes this by sending records back to back with no gap. It then checks at the strobe cycle that ready is still high for an ordinary record and low for the terminating record. It also checks that the following record decodes with the right byte order. A second overlap is a byte offered on the unselected source while a record is half received; the next write must show the address the selected source sent.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PH_ADDR_HI = 2'd0,
        PH_ADDR_LO = 2'd1,
        PH_DATA    = 2'd2
    } phase_e;

    typedef struct packed {
        logic  io;
        addr_t addr;
        byte_t data;
    } wr_rec_t;

    localparam addr_t EXIT_IO_ADDR = 16'h0024;
    localparam byte_t EXIT_DATA    = 8'h80;

    // Turn three bytes into one write; the space bit is removed from I/O addresses.
    function automatic wr_rec_t build_rec(byte_t hi, byte_t lo, byte_t d);
        wr_rec_t r;
        r.io   = hi[BYTE_W-1];
        r.addr = {hi, lo};
        if (r.io) begin
            r.addr[ADDR_W-1] = 1'b0;
        end
        r.data = d;
        return r;
    endfunction

    function automatic logic is_exit(wr_rec_t r);
        return r.io && (r.addr == EXIT_IO_ADDR) && (r.data == EXIT_DATA);
    endfunction

endpackage

// File: rtl/boot_src_sel.sv
module boot_src_sel
    import boot_pkg::*;
#(
    parameter int SRC_N = 2,
    localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEL_W-1:0]       strap_sel,
    input  logic                   enable,
    input  logic [SRC_N-1:0]       src_valid,
    input  logic [SRC_N-1:0][BYTE_W-1:0] src_data,
    output logic [SRC_N-1:0]       src_ready,
    output logic                   take,
    output byte_t                  take_byte
);

    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= strap_sel;
        end
    end

    for (genvar g = 0; g < SRC_N; g++) begin : g_rdy
        assign src_ready[g] = enable && (sel_q == SEL_W'(g));
    end

    always_comb begin
        take      = 1'b0;
        take_byte = '0;
        for (int i = 0; i < SRC_N; i++) begin
            if (src_ready[i] && src_valid[i]) begin
                take      = 1'b1;
                take_byte = src_data[i];
            end
        end
    end

endmodule

// File: rtl/boot_rec_seq.sv
module boot_rec_seq
    import boot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    take,
    input  byte_t   take_byte,
    output logic    rec_valid,
    output wr_rec_t rec
);

    phase_e phase_q;
    byte_t  hi_q;
    byte_t  lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR_HI;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (take) begin
            unique case (phase_q)
                PH_ADDR_HI: begin
                    hi_q    <= take_byte;
                    phase_q <= PH_ADDR_LO;
                end
                PH_ADDR_LO: begin
                    lo_q    <= take_byte;
                    phase_q <= PH_DATA;
                end
                default: begin
                    phase_q <= PH_ADDR_HI;
                end
            endcase
        end
    end

    assign rec_valid = take && (phase_q == PH_DATA);
    assign rec       = build_rec(hi_q, lo_q, take_byte);

endmodule

// File: rtl/boot_wr_ctl.sv
module boot_wr_ctl
    import boot_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    boot_strap,
    input  logic    rec_valid,
    input  wr_rec_t rec,
    output logic    wr_en,
    output wr_rec_t wr_q,
    output logic    active,
    output logic    exit_pend,
    output logic    go
);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= boot_strap;
            wr_en     <= 1'b0;
            wr_q      <= '0;
            exit_pend <= 1'b0;
            go        <= 1'b0;
        end else begin
            wr_en     <= rec_valid;
            exit_pend <= rec_valid && is_exit(rec);
            go        <= exit_pend;
            if (rec_valid) begin
                wr_q <= rec;
            end
            if (exit_pend) begin
                active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/boot_triplet_loader.sv
module boot_triplet_loader
    import boot_pkg::*;
#(
    parameter logic [15:0] FETCH_VECTOR = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_a,
    input  logic        strap_b,
    input  logic        strap_src,
    input  logic        ser_valid,
    input  logic [7:0]  ser_data,
    output logic        ser_ready,
    input  logic        par_valid,
    input  logic [7:0]  par_data,
    output logic        par_ready,
    output logic        wr_en,
    output logic        wr_io,
    output logic [15:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        boot_active,
    output logic        fetch_go,
    output logic [15:0] fetch_addr
);

    localparam int SRC_N = 2;

    logic [SRC_N-1:0]             src_valid;
    logic [SRC_N-1:0][BYTE_W-1:0] src_data;
    logic [SRC_N-1:0]             src_ready;
    logic                         take;
    byte_t                        take_byte;
    logic                         rec_valid;
    wr_rec_t                      rec;
    wr_rec_t                      wr_q;
    logic                         exit_pend;

    assign src_valid = {par_valid, ser_valid};
    assign src_data  = {par_data, ser_data};
    assign ser_ready = src_ready[0];
    assign par_ready = src_ready[1];

    boot_src_sel #(.SRC_N(SRC_N)) u_src (
        .clk       (clk),
        .rst       (rst),
        .strap_sel (strap_src),
        .enable    (boot_active && !exit_pend),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .take      (take),
        .take_byte (take_byte)
    );

    boot_rec_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_byte (take_byte),
        .rec_valid (rec_valid),
        .rec       (rec)
    );

    boot_wr_ctl u_wr (
        .clk        (clk),
        .rst        (rst),
        .boot_strap (strap_a && strap_b),
        .rec_valid  (rec_valid),
        .rec        (rec),
        .wr_en      (wr_en),
        .wr_q       (wr_q),
        .active     (boot_active),
        .exit_pend  (exit_pend),
        .go         (fetch_go)
    );

    assign wr_io      = wr_q.io;
    assign wr_addr    = wr_q.addr;
    assign wr_data    = wr_q.data;
    assign fetch_addr = FETCH_VECTOR;

endmodule

// File: rtl/boot_triplet_loader_chk.sv
module boot_triplet_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        ser_ready,
    input logic        par_ready,
    input logic        wr_en,
    input logic        wr_io,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        boot_active,
    input logic        fetch_go
);

    // R3: I/O writes never carry the space bit in the address
    a_r3_io_bit15_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_io) |-> !wr_addr[15]);

    // R5: the strobe is a single clock wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R6: at most one source is offered ready
    a_r6_one_ready: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ser_ready, par_ready}));

    // R7: the terminating write ends boot and starts fetch next cycle
    a_r7_exit: assert property (@(posedge clk) disable iff (rst)
        (boot_active && wr_en && wr_io && wr_addr == 16'h0024 && wr_data == 8'h80)
        |=> (!boot_active && fetch_go));

    // R7: fetch start is a single pulse
    a_r7_go_pulse: assert property (@(posedge clk) disable iff (rst)
        fetch_go |=> !fetch_go);

    // R8: idle engine neither takes bytes nor writes
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !boot_active |-> (!ser_ready && !par_ready && !wr_en));

    // R8: once left, boot mode stays off until reset
    a_r8_sticky_off: assert property (@(posedge clk) disable iff (rst)
        !boot_active |=> !boot_active);

    // R9: ready is withheld during the terminating strobe
    a_r9_exit_no_ready: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_io && wr_addr == 16'h0024 && wr_data == 8'h80)
        |-> (!ser_ready && !par_ready));

endmodule

bind boot_triplet_loader boot_triplet_loader_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ser_ready   (ser_ready),
    .par_ready   (par_ready),
    .wr_en       (wr_en),
    .wr_io       (wr_io),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .boot_active (boot_active),
    .fetch_go    (fetch_go)
);

// File: tb/sim_boot_triplet_loader.sv
module sim_boot_triplet_loader;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_a = 1'b1, strap_b = 1'b1, strap_src = 1'b0;
    logic        ser_valid = 1'b0, par_valid = 1'b0;
    logic [7:0]  ser_data = '0, par_data = '0;
    logic        ser_ready, par_ready, wr_en, wr_io, boot_active, fetch_go;
    logic [15:0] wr_addr, fetch_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int cyc    = 0;
    logic use_par = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_triplet_loader u0 (
        .clk(clk), .rst(rst), .strap_a(strap_a), .strap_b(strap_b), .strap_src(strap_src),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready),
        .par_valid(par_valid), .par_data(par_data), .par_ready(par_ready),
        .wr_en(wr_en), .wr_io(wr_io), .wr_addr(wr_addr), .wr_data(wr_data),
        .boot_active(boot_active), .fetch_go(fetch_go), .fetch_addr(fetch_addr)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (!rst && wr_en) pulses <= pulses + 1;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic b, input logic s);
        @(negedge clk);
        strap_a = a; strap_b = b; strap_src = s; rst = 1'b1;
        ser_valid = 0; par_valid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        use_par = s;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        ser_valid = 0; par_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge where the byte is taken on the next edge.
    task automatic offer(input logic [7:0] b);
        if (use_par) begin par_valid = 1; par_data = b; end
        else begin ser_valid = 1; ser_data = b; end
        while (!(use_par ? par_ready : ser_ready)) @(negedge clk);
    endtask

    task automatic send_rec(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d,
                            input int gap, input string tag);
        logic [15:0] ea;
        logic        eio;
        int          p0;
        eio = hi[7];
        ea  = {hi & 8'h7F, lo};
        if (!eio) ea = {hi, lo};
        idle(gap); offer(hi); @(negedge clk);
        idle(gap); offer(lo); @(negedge clk);
        p0 = pulses;
        idle(gap);
        chk(pulses == p0, {tag, " R5 no write for partial record"}, pulses, p0);
        offer(d); @(negedge clk);
        ser_valid = 0; par_valid = 0;
        chk(wr_en && wr_io == eio && wr_addr == ea && wr_data == d,
            {tag, (eio ? " R3 io record" : " R2 mem record")},
            {wr_en, wr_io, wr_addr, wr_data}, {1'b1, eio, ea, d});
    endtask

    initial begin
        wait (cyc >= WATCHDOG);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base;
        // R1 reset state, serial selected
        do_reset(1, 1, 0);
        chk(boot_active && !wr_en && ser_ready && !par_ready && !fetch_go, "R1 R6 reset state",
            {boot_active, wr_en, ser_ready, par_ready, fetch_go}, 5'b10100);

        // R2 R3 R4 sweep over every high byte with varying gaps
        base = pulses;
        for (int h = 0; h < 256; h++) begin
            send_rec(8'(h), 8'((h * 37 + 11) & 255), 8'(h ^ 8'hA5), h % 3, "sweep");
        end
        @(negedge clk);
        chk(pulses - base == 256, "R5 one pulse per record", pulses - base, 256);

        // R4 long stall mid-record
        idle(1); offer(8'h12); @(negedge clk); offer(8'h34); @(negedge clk);
        base = pulses;
        idle(60);
        chk(pulses == base, "R4 stall keeps position, no write", pulses, base);
        offer(8'h56); @(negedge clk); ser_valid = 0;
        chk(wr_en && wr_addr == 16'h1234 && wr_data == 8'h56 && !wr_io, "R4 resume after stall",
            {wr_addr, wr_data}, 24'h123456);

        // R6 bytes on the parallel port are ignored while serial is selected
        idle(1);
        offer(8'h21); @(negedge clk); ser_valid = 0;
        par_valid = 1; par_data = 8'hEE;
        repeat (5) @(negedge clk);
        chk(!par_ready, "R6 unselected ready low", par_ready, 0);
        par_valid = 0;
        offer(8'h43); @(negedge clk); offer(8'h65); @(negedge clk); ser_valid = 0;
        chk(wr_en && wr_addr == 16'h2143 && wr_data == 8'h65, "R6 unselected bytes ignored",
            {wr_addr, wr_data}, 24'h214365);

        // R9 back to back: ready stays up during an ordinary strobe
        idle(1);
        offer(8'h05); @(negedge clk); offer(8'h06); @(negedge clk); offer(8'h07); @(negedge clk);
        ser_data = 8'h8A;
        chk(wr_en && ser_ready, "R9 ready during ordinary strobe", {wr_en, ser_ready}, 2'b11);
        @(negedge clk);
        offer(8'hBC); @(negedge clk); offer(8'hDE); @(negedge clk); ser_valid = 0;
        chk(wr_en && wr_io && wr_addr == 16'h0ABC && wr_data == 8'hDE, "R9 R3 overlapped record",
            {wr_io, wr_addr, wr_data}, {1'b1, 16'h0ABC, 8'hDE});

        // R7 terminating record
        idle(2);
        offer(8'h80); @(negedge clk); offer(8'h24); @(negedge clk); offer(8'h80); @(negedge clk);
        chk(wr_en && wr_io && wr_addr == 16'h0024 && wr_data == 8'h80 && boot_active,
            "R7 exit write issued", {wr_en, wr_io, wr_addr, wr_data, boot_active},
            {1'b1, 1'b1, 16'h0024, 8'h80, 1'b1});
        chk(!ser_ready, "R9 no ready during exit strobe", ser_ready, 0);
        @(negedge clk);
        chk(!boot_active && fetch_go && fetch_addr == 16'h0000, "R7 boot off, fetch from zero",
            {boot_active, fetch_go, fetch_addr}, {1'b0, 1'b1, 16'h0000});
        @(negedge clk);
        chk(!fetch_go, "R7 fetch pulse one cycle", fetch_go, 0);

        // R8 bytes after exit are ignored
        base = pulses;
        ser_data = 8'h01;
        repeat (12) @(negedge clk);
        chk(pulses == base && !ser_ready && !par_ready && !boot_active, "R8 idle after exit",
            {pulses - base, ser_ready}, 0);
        ser_valid = 0;

        // R6 parallel source selected
        do_reset(1, 1, 1);
        chk(par_ready && !ser_ready && boot_active, "R6 parallel selected",
            {par_ready, ser_ready}, 2'b10);
        ser_valid = 1; ser_data = 8'h99;
        for (int h = 0; h < 256; h += 17) begin
            send_rec(8'(h), 8'(255 - h), 8'(h + 3), h % 2, "par");
        end
        ser_valid = 0;

        // R1 only both straps high enables boot
        do_reset(1, 0, 0);
        ser_valid = 1; ser_data = 8'h11;
        repeat (6) @(negedge clk);
        chk(!boot_active && !ser_ready && !wr_en, "R1 R8 strap_b low idle",
            {boot_active, ser_ready, wr_en}, 0);
        do_reset(0, 1, 0);
        chk(!boot_active && !ser_ready && !par_ready, "R1 strap_a low idle",
            {boot_active, ser_ready, par_ready}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule